// File: doc/BRIEF.md
# Timekeeping Holding Registers with Read and Write Freeze

This block sits between a set of free-running BCD timekeeping counters and the software-visible time registers. The counters present a packed snapshot of eight byte-wide fields and a one-cycle seconds tick. In byte order from bit 0 up, the fields are seconds, minutes, hours, weekday, day of month, month, year and century. The century field holds two BCD digits, one per nibble, each counting 0 to 9, so it spans 0 to 99. When neither freeze bit is set, the holding registers take a fresh copy of the snapshot on every tick.

Software sees nine byte registers on a simple bus. Addresses 0 to 7 are the time fields and address 8 is the control register. Control bit 0 freezes the holding copy so that a multi-byte read is coherent. Control bit 1 freezes the copy and opens the time fields for writing. When bit 1 is cleared, and only if software wrote a time field while it was set, the block raises a one-cycle load strobe. The new base time then goes to the counters on a parallel bus.

Top module: `rtc_hold_regs`

## Requirements
- R1: After reset, every time register and the control register read 0 and `load_stb` is low.
- R2: With both control bits 0, a `tick` copies `cnt_time` into the time registers. Byte i of `cnt_time` (bits 8i+7..8i) goes to address i, and it is readable in the cycle after the tick edge.
- R3: While control bit 0 is 1, ticks leave the time registers unchanged. After bit 0 is cleared, the next tick copies the snapshot again.
- R4: A bus write to addresses 0 to 7 while control bit 1 is 0 has no effect. This includes the case where control bit 0 is 1, since the read freeze works without the write freeze.
- R5: While control bit 1 is 1, ticks are ignored, and bus writes to addresses 0 to 7 store the written byte.
- R6: A control write that clears bit 1, after at least one time write during the write freeze, pulses `load_stb` high for exactly the one cycle after that write edge. While `load_stb` is high, `load_time` carries all eight time registers in the same byte order as `cnt_time`.
- R7: Clearing control bit 1 when no time register was written during the freeze produces no `load_stb` pulse.
- R8: The record of a pending change is cleared by the load. A later set-and-clear of bit 1 with no time write produces no pulse.
- R9: The control register at address 8 reads back bit 0 (read freeze) and bit 1 (write freeze), and its bits 7..2 read as 0.
- R10: Addresses 9 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 8 | Read data for `addr` (combinational) |
| tick | input | 1 | One-cycle seconds tick from the counters |
| cnt_time | input | 64 | Counter snapshot, byte i belongs to address i |
| load_stb | output | 1 | One-cycle strobe to load the counters |
| load_time | output | 64 | New base time for the counters |

## Verification
The bench clears the write freeze with no time write pending, both straight after reset and after a completed load. A design that tracked the change badly would emit a spurious counter load there and overwrite the running time. It writes time fields while only the read freeze is set, which catches a design that let the read bit open the registers. It tests that ticks are held off under each freeze bit and resume once the bit is cleared. It also checks that the strobe lasts exactly one cycle and that `load_time` carries the edited fields next to the untouched ones, so a stuck strobe or a byte-order swap shows up.

// File: rtl/rtc_hold_regs.sv
module rtc_hold_regs #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int AW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic                we,
  output logic [DW-1:0]       rdata,
  input  logic                tick,
  input  logic [NREG*DW-1:0]  cnt_time,
  output logic                load_stb,
  output logic [NREG*DW-1:0]  load_time
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NREG);

  logic [NREG*DW-1:0] time_q;
  logic rd_frz, wr_frz, dirty, load_q;

  wire ctl_wr  = we && (addr == CTRL_ADDR);
  wire tm_wr   = we && wr_frz && ({1'b0, addr} < (AW+1)'(NREG));
  wire refresh = tick && !rd_frz && !wr_frz;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        time_q[g*DW +: DW] <= '0;
      else if (tm_wr && addr == AW'(g))
        time_q[g*DW +: DW] <= wdata;
      else if (refresh)
        time_q[g*DW +: DW] <= cnt_time[g*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_frz <= 1'b0;
      wr_frz <= 1'b0;
      dirty  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (tm_wr) dirty <= 1'b1;
      if (ctl_wr) begin
        rd_frz <= wdata[0];
        wr_frz <= wdata[1];
        if (wr_frz && !wdata[1] && dirty) begin
          load_q <= 1'b1;
          dirty  <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (addr == AW'(i)) rdata = time_q[i*DW +: DW];
    if (addr == CTRL_ADDR) rdata = {{(DW-2){1'b0}}, wr_frz, rd_frz};
  end

  assign load_stb  = load_q;
  assign load_time = time_q;

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q);
  a_r7_load_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_q) |-> $past(dirty) && $past(wr_frz) && !wr_frz);
  a_r8_change_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> !dirty);
  a_r3_read_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_frz && !tm_wr) |=> $stable(time_q));
  a_r4_closed_when_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_frz && !tick) |=> $stable(time_q));
endmodule

// File: tb/test_rtc_hold_regs.sv
module test_rtc_hold_regs;
  logic clk = 0, rst_n = 0, we = 0, tick = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [63:0] cnt_time = 0, load_time;
  logic load_stb;
  int n_chk = 0, n_bad = 0;

  rtc_hold_regs i_rtc_hold_regs (.clk, .rst_n, .addr, .wdata, .we, .rdata,
    .tick, .cnt_time, .load_stb, .load_time);

  always #2 clk = ~clk;

  localparam logic [63:0] S1 = 64'h20_24_12_31_03_23_59_45;
  localparam logic [63:0] S2 = 64'h20_25_01_01_04_00_00_00;
  localparam logic [63:0] S3 = 64'h21_99_09_15_02_11_22_33;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_tick(input logic [63:0] snap);
    @(negedge clk); cnt_time = snap; tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic chk_all(input logic [63:0] exp, input string tag);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), d);
      chk({56'h0, d}, {56'h0, exp[8*i +: 8]}, tag);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk_all(64'h0, "R1 time regs");
    rd(4'd8, d); chk({56'h0, d}, 64'h0, "R1 control");
    chk({63'h0, load_stb}, 64'h0, "R1 load_stb");
  endtask

  task automatic t_no_change(input string tag);
    wr(4'd8, 8'h02);
    wr(4'd8, 8'h00);
    chk({63'h0, load_stb}, 64'h0, tag);
    @(negedge clk); chk({63'h0, load_stb}, 64'h0, tag);
  endtask

  task automatic t_tick;
    pulse_tick(S1);
    chk_all(S1, "R2 refresh");
  endtask

  task automatic t_read_freeze;
    logic [7:0] d;
    wr(4'd8, 8'h01);
    rd(4'd8, d); chk({56'h0, d}, 64'h1, "R9 rd bit readback");
    pulse_tick(S2);
    chk_all(S1, "R3 frozen");
    wr(4'd0, 8'h11);
    rd(4'd0, d); chk({56'h0, d}, 64'h45, "R4 write ignored under read freeze");
    wr(4'd8, 8'h00);
    wr(4'd1, 8'h77);
    rd(4'd1, d); chk({56'h0, d}, 64'h59, "R4 write ignored unlocked");
    pulse_tick(S2);
    chk_all(S2, "R3 resumed");
  endtask

  task automatic t_write;
    logic [7:0] d;
    logic [63:0] exp;
    wr(4'd8, 8'h02);
    rd(4'd8, d); chk({56'h0, d}, 64'h2, "R9 wr bit readback");
    pulse_tick(S3);
    chk_all(S2, "R5 tick ignored");
    wr(4'd2, 8'h07);
    wr(4'd7, 8'h21);
    exp = S2; exp[23:16] = 8'h07; exp[63:56] = 8'h21;
    chk_all(exp, "R5 written");
    chk({63'h0, load_stb}, 64'h0, "R6 no early load");
    wr(4'd8, 8'h00);
    chk({63'h0, load_stb}, 64'h1, "R6 load pulse");
    chk(load_time, exp, "R6 load_time");
    @(negedge clk); chk({63'h0, load_stb}, 64'h0, "R6 pulse one cycle");
  endtask

  task automatic t_bad_addr;
    logic [7:0] d;
    logic [63:0] exp;
    exp = S2; exp[23:16] = 8'h07; exp[63:56] = 8'h21;
    wr(4'd8, 8'hFC);
    rd(4'd8, d); chk({56'h0, d}, 64'h0, "R9 upper bits zero");
    wr(4'd12, 8'hFF);
    rd(4'd12, d); chk({56'h0, d}, 64'h0, "R10 read high addr");
    rd(4'd8, d); chk({56'h0, d}, 64'h0, "R10 control untouched");
    chk_all(exp, "R10 time untouched");
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_no_change("R7 no pulse without change");
    t_tick;
    t_read_freeze;
    t_write;
    t_no_change("R8 change consumed");
    t_bad_addr;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule